// File: doc/BRIEF.md
# SCSI Byte-to-Word DMA FIFO Bridge

This block sits between the 8-bit data port of a SCSI bus controller and a 16-bit DMA engine. It buffers the data stream in a word FIFO (8 KiB by default) and packs or unpacks bytes into words, in whichever direction the control register selects. Software programs a byte count before the bus enters a data phase; that count falls by one for every byte that crosses the SCSI side, so after the transfer it reads back as the residual.

After a receive ends, a byte or word that the DMA side never took stays visible through a data register, so software can copy the tail by hand. A control/status register holds active-low reset bits for the FIFO and for the SCSI controller, an interrupt enable and the direction bit, and reports FIFO empty together with two sticky DMA error flags. The interrupt output combines those error flags with the controller's own interrupt.

Registers (reg_addr): 0 = control/status, 1 = byte count, 2 = leftover data (read only). Control bits, written and read at reg_addr 0: bit 0 FIFO release (active-low reset), bit 1 SCSI controller release (active-low reset), bit 2 interrupt enable, bit 3 send. Status bits read at reg_addr 0: bit 8 FIFO empty, bit 9 DMA conflict, bit 10 DMA bus error.

Top module: `scsi_fifo_bridge`

## Requirements
- R1: After rst the control bits are all 0, the count reads 0, reg_addr 0 reads 16'h0100 (only the empty flag set), irq is 0 and scsi_reset_o is 1.
- R2: Control bit 0 and bit 1 are active-low resets: with bit 0 at 0 the FIFO is empty and no byte or word moves (sc_in_ready, sc_out_valid and dma_req are 0); scsi_reset_o equals the inverse of bit 1.
- R3: A write to the count register (reg_addr 1) is ignored while bus_phase is 3'd0 (data out) or 3'd1 (data in) and takes effect in any other phase.
- R4: The count falls by one for each byte accepted on sc_in (receive) or taken from sc_out (send), no byte moves when it is 0, and its 16 bits read back at reg_addr 1.
- R5: In receive (bit 3 = 0) each pair of SCSI bytes is offered on dma_rdata as one word, the first byte in bits 15:8, with dma_req high while a word is stored; a word moves when dma_req and dma_ack are both 1.
- R6: When a receive ends on an odd byte, reg_addr 2 reads that byte in bits 15:8 with bits 7:0 zero, and the empty flag is 0.
- R7: When a full received word is still in the FIFO, reg_addr 2 reads the oldest such word, earlier byte in bits 15:8 and later byte in bits 7:0.
- R8: In send (bit 3 = 1) the block requests exactly ceil(count/2) words through dma_req/dma_ack, taking dma_wdata on each, and presents each word's bits 15:8 then 7:0 on sc_out_data; the unused low byte of an odd final word is dropped.
- R9: Pulsing control bit 0 low empties the FIFO and the partial word but leaves the count unchanged.
- R10: Status bit 8 is 1 exactly when no byte is buffered; bits 9 and 10 latch pulses on dma_conflict_in and dma_bus_err_in and clear while control bit 0 is 0.
- R11: irq is control bit 2 AND the OR of status bits 9, 10 and scsi_irq_in.
- R12: The FIFO never holds more than its depth; in receive, sc_in_ready is 0 when the FIFO is full and a half word is already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| bus_phase | input | 3 | Current SCSI bus phase |
| scsi_irq_in | input | 1 | Interrupt from the SCSI controller |
| dma_conflict_in | input | 1 | DMA conflict pulse |
| dma_bus_err_in | input | 1 | DMA bus error pulse |
| irq | output | 1 | Combined interrupt |
| scsi_reset_o | output | 1 | Reset to the SCSI controller, active high |
| sc_in_valid | input | 1 | Receive byte offered by the controller |
| sc_in_data | input | 8 | Receive byte |
| sc_in_ready | output | 1 | Bridge accepts the receive byte |
| sc_out_valid | output | 1 | Send byte offered to the controller |
| sc_out_data | output | 8 | Send byte |
| sc_out_ready | input | 1 | Controller takes the send byte |
| dma_req | output | 1 | Word request to the DMA side |
| dma_ack | input | 1 | DMA side completes the word |
| dma_wdata | input | 16 | Word from memory (send) |
| dma_rdata | output | 16 | Word to memory (receive) |

## Verification
The hardest state to reach is a full FIFO with a half word also held, where the byte side must stall while the residual count is still non-zero. The bench builds the bridge with a four-word FIFO, holds dma_ack low and offers more bytes than fit, then checks the stall, the residual, and that a FIFO reset pulse clears the data but leaves the count. Sweeps over every transfer length from one to nine bytes in both directions cover the odd and even tails.

// File: rtl/scsi_fifo_pkg.sv
package scsi_fifo_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam logic [2:0] PH_DATA_OUT = 3'd0;
    localparam logic [2:0] PH_DATA_IN  = 3'd1;

    localparam int ST_EMPTY_BIT = 8;
    localparam int ST_CONF_BIT  = 9;
    localparam int ST_BERR_BIT  = 10;

    typedef struct packed {
        logic send;
        logic irq_en;
        logic scsi_rel;
        logic fifo_rel;
    } ctrl_t;

    typedef struct packed {
        logic       half;
        logic [7:0] hi;
    } pack_t;

    function automatic logic is_data_phase(input logic [2:0] ph);
        return (ph == PH_DATA_OUT) || (ph == PH_DATA_IN);
    endfunction

    function automatic logic [15:0] words_for_bytes(input logic [15:0] n);
        logic [16:0] t;
        t = {1'b0, n} + 17'd1;
        return t[16:1];
    endfunction

endpackage

// File: rtl/sfb_word_fifo.sv
module sfb_word_fifo #(
    parameter int DEPTH = 4096,
    parameter int W     = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic [AW:0]  level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;

    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

    assign empty = (level == '0);
    assign full  = (level == DEPTH_L);
    assign head  = mem[rp];

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/sfb_rx_pack.sv
module sfb_rx_pack
    import scsi_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic        cnt_nz,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        fifo_full,
    output logic        in_ready,
    output logic        move,
    output logic        push,
    output logic [15:0] push_data,
    output pack_t       st
);
    assign in_ready  = en && cnt_nz && (!st.half || !fifo_full);
    assign move      = in_valid && in_ready;
    assign push      = move && st.half;
    assign push_data = {st.hi, in_data};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st <= '0;
        end else if (move) begin
            if (st.half) begin
                st.half <= 1'b0;
            end else begin
                st.half <= 1'b1;
                st.hi   <= in_data;
            end
        end
    end
endmodule

// File: rtl/sfb_tx_unpack.sv
module sfb_tx_unpack #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] count,
    input  logic             fifo_empty,
    input  logic [15:0]      head,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             move,
    output logic             pop
);
    logic lo_next;

    assign out_valid = en && (count != '0) && !fifo_empty;
    assign out_data  = lo_next ? head[7:0] : head[15:8];
    assign move      = out_valid && out_ready;
    assign pop       = move && (lo_next || (count == CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lo_next <= 1'b0;
        end else if (move) begin
            lo_next <= !pop;
        end
    end
endmodule

// File: rtl/sfb_byte_count.sv
module sfb_byte_count
    import scsi_fifo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [15:0]      load_val,
    input  logic             byte_dec,
    input  logic             word_dec,
    output logic [CNT_W-1:0] count,
    output logic             cnt_nz,
    output logic             words_nz
);
    logic [CNT_W-1:0] words_left;

    assign cnt_nz   = (count != '0);
    assign words_nz = (words_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count      <= '0;
            words_left <= '0;
        end else if (load) begin
            count      <= CNT_W'(load_val);
            words_left <= CNT_W'(words_for_bytes(load_val));
        end else begin
            if (byte_dec && cnt_nz)   count      <= count - 1'b1;
            if (word_dec && words_nz) words_left <= words_left - 1'b1;
        end
    end
endmodule

// File: rtl/scsi_fifo_bridge.sv
module scsi_fifo_bridge
    import scsi_fifo_pkg::*;
#(
    parameter int FIFO_BYTES = 8192,
    parameter int CNT_W      = 16,
    localparam int DEPTH     = FIFO_BYTES / 2,
    localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic [2:0]  bus_phase,
    input  logic        scsi_irq_in,
    input  logic        dma_conflict_in,
    input  logic        dma_bus_err_in,
    output logic        irq,
    output logic        scsi_reset_o,
    input  logic        sc_in_valid,
    input  logic [7:0]  sc_in_data,
    output logic        sc_in_ready,
    output logic        sc_out_valid,
    output logic [7:0]  sc_out_data,
    input  logic        sc_out_ready,
    output logic        dma_req,
    input  logic        dma_ack,
    input  logic [15:0] dma_wdata,
    output logic [15:0] dma_rdata
);
    ctrl_t ctrl;
    logic  err_conf, err_bus;

    logic [CNT_W-1:0] count;
    logic             cnt_nz, words_nz;

    logic        f_push, f_pop, f_empty, f_full;
    logic [15:0] f_push_data, f_head;
    logic [AW:0] f_level;

    logic        rx_move, rx_push;
    logic [15:0] rx_push_data;
    pack_t       rx_st;
    logic        tx_move, tx_pop;

    wire fifo_clr  = !ctrl.fifo_rel;
    wire rx_en     = ctrl.fifo_rel && !ctrl.send;
    wire tx_en     = ctrl.fifo_rel && ctrl.send;
    wire cnt_wr    = reg_wr && (reg_addr == ADDR_CNT) && !is_data_phase(bus_phase);
    wire byte_move = rx_move || tx_move;
    wire dma_xfer  = dma_req && dma_ack;
    wire buf_empty = f_empty && !rx_st.half;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            err_conf <= 1'b0;
            err_bus  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == ADDR_CTRL) ctrl <= ctrl_t'(reg_wdata[3:0]);
            if (fifo_clr) begin
                err_conf <= 1'b0;
                err_bus  <= 1'b0;
            end else begin
                if (dma_conflict_in) err_conf <= 1'b1;
                if (dma_bus_err_in)  err_bus  <= 1'b1;
            end
        end
    end

    assign scsi_reset_o = !ctrl.scsi_rel;
    assign irq          = ctrl.irq_en && (err_conf || err_bus || scsi_irq_in);

    assign dma_req   = ctrl.send ? (tx_en && !f_full && words_nz) : (rx_en && !f_empty);
    assign dma_rdata = f_head;

    assign f_push      = ctrl.send ? dma_xfer : rx_push;
    assign f_push_data = ctrl.send ? dma_wdata : rx_push_data;
    assign f_pop       = ctrl.send ? tx_pop : dma_xfer;

    sfb_word_fifo #(.DEPTH(DEPTH), .W(16)) u_fifo (
        .clk(clk), .rst(rst), .clr(fifo_clr),
        .push(f_push), .push_data(f_push_data), .pop(f_pop),
        .head(f_head), .empty(f_empty), .full(f_full), .level(f_level)
    );

    sfb_rx_pack u_pack (
        .clk(clk), .rst(rst), .clr(fifo_clr), .en(rx_en), .cnt_nz(cnt_nz),
        .in_valid(sc_in_valid), .in_data(sc_in_data), .fifo_full(f_full),
        .in_ready(sc_in_ready), .move(rx_move), .push(rx_push),
        .push_data(rx_push_data), .st(rx_st)
    );

    sfb_tx_unpack #(.CNT_W(CNT_W)) u_unpack (
        .clk(clk), .rst(rst), .clr(fifo_clr), .en(tx_en), .count(count),
        .fifo_empty(f_empty), .head(f_head), .out_ready(sc_out_ready),
        .out_valid(sc_out_valid), .out_data(sc_out_data),
        .move(tx_move), .pop(tx_pop)
    );

    sfb_byte_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .load(cnt_wr), .load_val(reg_wdata),
        .byte_dec(byte_move), .word_dec(ctrl.send && dma_xfer),
        .count(count), .cnt_nz(cnt_nz), .words_nz(words_nz)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[3:0]          = ctrl;
                reg_rdata[ST_EMPTY_BIT] = buf_empty;
                reg_rdata[ST_CONF_BIT]  = err_conf;
                reg_rdata[ST_BERR_BIT]  = err_bus;
            end
            ADDR_CNT:  reg_rdata = 16'(count);
            ADDR_DATA: begin
                if (rx_st.half)    reg_rdata = {rx_st.hi, 8'h00};
                else if (!f_empty) reg_rdata = f_head;
            end
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/scsi_fifo_bridge_chk.sv
module scsi_fifo_bridge_chk
    import scsi_fifo_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int AW    = 12,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [AW:0]      f_level,
    input logic             byte_move,
    input logic [CNT_W-1:0] count,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [2:0]       bus_phase,
    input logic             irq,
    input ctrl_t            ctrl,
    input logic             sc_in_ready,
    input logic             sc_out_valid,
    input logic             dma_req
);
    wire cnt_write = reg_wr && (reg_addr == ADDR_CNT);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        f_level <= (AW+1)'(DEPTH)); // R12
    AST_CNT_LOCK: assert property (@(posedge clk) disable iff (rst)
        (cnt_write && is_data_phase(bus_phase)) |=> (count == $past(count) - CNT_W'($past(byte_move)))); // R3
    AST_NO_MOVE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !byte_move); // R4
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |-> !irq); // R11
    AST_DIR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sc_in_ready && sc_out_valid)); // R8
    AST_FRST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl.fifo_rel |-> (!dma_req && !byte_move)); // R2
    AST_FRST_CNT: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.fifo_rel && !cnt_write) |=> $stable(count)); // R9
endmodule

bind scsi_fifo_bridge scsi_fifo_bridge_chk #(.DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .f_level(f_level), .byte_move(byte_move), .count(count),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .bus_phase(bus_phase), .irq(irq),
    .ctrl(ctrl), .sc_in_ready(sc_in_ready), .sc_out_valid(sc_out_valid),
    .dma_req(dma_req)
);

// File: tb/sim_scsi_fifo_bridge.sv
`timescale 1ns/1ps
module sim_scsi_fifo_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  bus_phase = 3'd2;
    logic        scsi_irq_in = 1'b0, dma_conflict_in = 1'b0, dma_bus_err_in = 1'b0;
    logic        irq, scsi_reset_o;
    logic        sc_in_valid = 1'b0;
    logic [7:0]  sc_in_data = '0;
    logic        sc_in_ready, sc_out_valid;
    logic [7:0]  sc_out_data;
    logic        sc_out_ready = 1'b0;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic [15:0] dma_wdata = '0;
    logic [15:0] dma_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    scsi_fifo_bridge #(.FIFO_BYTES(8), .CNT_W(16)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_phase(bus_phase),
        .scsi_irq_in(scsi_irq_in), .dma_conflict_in(dma_conflict_in),
        .dma_bus_err_in(dma_bus_err_in), .irq(irq), .scsi_reset_o(scsi_reset_o),
        .sc_in_valid(sc_in_valid), .sc_in_data(sc_in_data), .sc_in_ready(sc_in_ready),
        .sc_out_valid(sc_out_valid), .sc_out_data(sc_out_data), .sc_out_ready(sc_out_ready),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] bval(input int n, input int i);
        return 8'(n * 37 + i * 11 + 5);
    endfunction

    function automatic logic [15:0] wval(input int n, input int j);
        return 16'(n * 1000 + j * 257 + 3);
    endfunction

    task automatic fifo_pulse(input logic [15:0] base);
        wr(2'd0, base & 16'hFFFE);
        wr(2'd0, base | 16'h0001);
    endtask

    logic [15:0] capw [0:31];
    int          ncapw, nin;

    task automatic rx_run(input int n, input bit drain, input int cycles);
        ncapw = 0; nin = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            sc_in_valid = (nin < n);
            sc_in_data  = bval(n, nin);
            dma_ack     = drain;
            #1;
            if (dma_req && dma_ack) begin capw[ncapw] = dma_rdata; ncapw++; end
            if (sc_in_valid && sc_in_ready) nin++;
        end
        @(negedge clk);
        sc_in_valid = 1'b0; dma_ack = 1'b0;
    endtask

    initial begin
        logic [15:0] d;
        int exp_w, nw, nb;
        logic [7:0] capb [0:31];
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl/status", d, 16'h0100);
        rd(2'd1, d); chk("R1 count", d, 16'h0000);
        chk("R1 irq", irq, 1'b0);
        chk("R2 scsi reset held", scsi_reset_o, 1'b1);
        wr(2'd0, 16'h0003);
        chk("R2 scsi reset released", scsi_reset_o, 1'b0);

        // R5 R6 R4 R10 receive sweep, DMA draining
        for (int n = 1; n <= 9; n++) begin
            fifo_pulse(16'h0003);
            bus_phase = 3'd2; wr(2'd1, 16'(n));
            bus_phase = 3'd1;
            rx_run(n, 1'b1, 3 * n + 6);
            chk("R4 bytes accepted", nin, n);
            chk("R5 word count", ncapw, n / 2);
            for (int j = 0; j < n / 2; j++)
                chk("R5 word packing", capw[j], {bval(n, 2*j), bval(n, 2*j+1)});
            rd(2'd1, d); chk("R4 residual zero", d, 16'h0000);
            rd(2'd0, d); chk("R10 empty flag", d[8], (n % 2 == 0));
            if (n % 2 == 1) begin
                rd(2'd2, d); chk("R6 odd leftover", d, {bval(n, n-1), 8'h00});
            end
        end

        // R7 untaken full word
        fifo_pulse(16'h0003);
        bus_phase = 3'd2; wr(2'd1, 16'd2);
        bus_phase = 3'd1;
        rx_run(2, 1'b0, 8);
        rd(2'd2, d); chk("R7 leftover word", d, {bval(2, 0), bval(2, 1)});
        chk("R5 dma_req with stored word", dma_req, 1'b1);

        // R12 stall with full FIFO and held half word
        fifo_pulse(16'h0003);
        bus_phase = 3'd2; wr(2'd1, 16'd10);
        bus_phase = 3'd1;
        rx_run(10, 1'b0, 20);
        chk("R12 bytes accepted before stall", nin, 9);
        rd(2'd1, d); chk("R12 residual at stall", d, 16'd1);
        @(negedge clk) sc_in_valid = 1'b1;
        #1 chk("R12 ready low when full", sc_in_ready, 1'b0);
        sc_in_valid = 1'b0;
        rd(2'd2, d); chk("R6 half word while full", d, {bval(10, 8), 8'h00});

        // R3 count write lockout
        bus_phase = 3'd1; wr(2'd1, 16'h0055);
        rd(2'd1, d); chk("R3 locked in data in", d, 16'd1);
        bus_phase = 3'd0; wr(2'd1, 16'h0066);
        rd(2'd1, d); chk("R3 locked in data out", d, 16'd1);

        // R9 R2 FIFO reset keeps count
        wr(2'd0, 16'h0002);
        @(negedge clk) sc_in_valid = 1'b1;
        #1 chk("R2 no movement in fifo reset", sc_in_ready, 1'b0);
        chk("R2 no dma_req in fifo reset", dma_req, 1'b0);
        sc_in_valid = 1'b0;
        wr(2'd0, 16'h0003);
        rd(2'd1, d); chk("R9 count kept", d, 16'd1);
        rd(2'd0, d); chk("R9 fifo emptied", d[8], 1'b1);
        bus_phase = 3'd3; wr(2'd1, 16'h0077);
        rd(2'd1, d); chk("R3 write takes in other phase", d, 16'h0077);

        // R8 send sweep
        for (int n = 1; n <= 9; n++) begin
            fifo_pulse(16'h000B);
            bus_phase = 3'd2; wr(2'd1, 16'(n));
            bus_phase = 3'd0;
            nw = 0; nb = 0;
            for (int c = 0; c < 3 * n + 8; c++) begin
                @(negedge clk);
                dma_ack = 1'b1; dma_wdata = wval(n, nw); sc_out_ready = 1'b1;
                #1;
                if (sc_out_valid) begin capb[nb] = sc_out_data; nb++; end
                if (dma_req) nw++;
            end
            @(negedge clk) dma_ack = 1'b0; sc_out_ready = 1'b0;
            exp_w = (n + 1) / 2;
            chk("R8 words requested", nw, exp_w);
            chk("R8 bytes sent", nb, n);
            for (int k = 0; k < n; k++)
                chk("R8 byte order", capb[k],
                    (k % 2 == 0) ? wval(n, k/2) >> 8 : wval(n, k/2) & 16'hFF);
            rd(2'd1, d); chk("R4 send residual", d, 16'h0000);
            chk("R8 no further request", dma_req, 1'b0);
        end

        // R10 R11 status and interrupt
        wr(2'd0, 16'h0007);
        @(negedge clk) dma_conflict_in = 1'b1;
        @(negedge clk) dma_conflict_in = 1'b0;
        rd(2'd0, d); chk("R10 conflict sticky", d[9], 1'b1);
        chk("R11 irq on conflict", irq, 1'b1);
        fifo_pulse(16'h0007);
        rd(2'd0, d); chk("R10 conflict cleared", d[9], 1'b0);
        chk("R11 irq idle", irq, 1'b0);
        @(negedge clk) dma_bus_err_in = 1'b1;
        @(negedge clk) dma_bus_err_in = 1'b0;
        rd(2'd0, d); chk("R10 bus error sticky", d[10], 1'b1);
        wr(2'd0, 16'h0003);
        #1 chk("R11 irq gated off", irq, 1'b0);
        fifo_pulse(16'h0007);
        @(negedge clk) scsi_irq_in = 1'b1;
        #1 chk("R11 scsi irq passes", irq, 1'b1);
        wr(2'd0, 16'h0003);
        #1 chk("R11 scsi irq gated", irq, 1'b0);
        scsi_irq_in = 1'b0;

        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule